// File: doc/BRIEF.md
# Wide-to-narrow bus width splitter

The splitter joins a wide host port to a narrow device port of a TileLink-UL style bus. One wide write or read request is taken on the host A channel. For every narrow lane whose byte-enable slice is non-zero it sends one narrow request to the device, lowest lane first, and lanes with an empty slice are skipped. Narrow acknowledgements may come back in any order. They are matched by a per-lane tag, and their read data is gathered lane by lane. Once every issued beat has been acknowledged, one wide response goes back carrying the host's source ID.

Every outgoing narrow beat gets fresh command and data check bytes for the narrow width. Every incoming narrow acknowledgement is checked against its own check bytes, and the combined wide response gets check bytes recomputed for the wide width. Only one wide transaction is in flight at a time, and the host A channel is held not-ready until its response has been taken.

Check-byte encoding used throughout: the data check byte is the XOR of all bytes of the data word. The command check byte is the XOR of the opcode (zero-extended to 8 bits), the size (zero-extended), both bytes of the byte mask (zero-extended to 16 bits) and the four address bytes. The response check byte is the XOR of the opcode, the size, the source (each zero-extended to 8 bits) and the error bit.

Top module: `wide_narrow_splitter`

## Requirements
- R1: `ha_ready_o` is 1 when idle. From the cycle after a host request is accepted until the cycle after its wide response handshake it is 0.
- R2: Each narrow beat for lane i carries address (host address with its low 4 bits cleared) + 4*i, data bits [32*i+31:32*i], mask nibble i, size 2, source tag i and the host opcode. Beats are issued in ascending lane order.
- R3: A lane whose mask nibble is zero produces no beat. A mask of 0xF0F0 gives beats for lanes 1 and 3 only. A mask of 0 gives no beat and still gives one wide response.
- R4: While `da_valid_o` is 1 and `da_ready_i` is 0, the beat stays valid and its address and tag do not change.
- R5: `da_cmd_intg_o` and `da_data_intg_o` follow the command and data check-byte encodings, applied to the narrow beat's own fields.
- R6: `dd_ready_o` is 1 while issued beats are unacknowledged. Acknowledgements are accepted in any order. Exactly one wide response appears, and only after all issued beats have been acknowledged.
- R7: The wide response has opcode 1 (AccessAckData) for a Get (opcode 4) and opcode 0 (AccessAck) for a PutFullData (opcode 0). It echoes the host source and size.
- R8: For a Get, the data of the acknowledgement with tag i is placed in wide lane i. Lanes not requested, and all lanes of a write response, are zero.
- R9: The wide error bit is the OR of the error bits of the acknowledgements and of any check-byte mismatch found on them. It starts at 0 for each new transaction.
- R10: `hd_rsp_intg_o` and `hd_data_intg_o` follow the response and data check-byte encodings, applied to the wide response fields.
- R11: While `hd_valid_o` is 1 and `hd_ready_i` is 0, the wide response stays valid with unchanged source, data and error.
- R12: In reset, `ha_ready_o` is 1 and `da_valid_o`, `dd_ready_o` and `hd_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ha_valid_i | input | 1 | Host request valid |
| ha_ready_o | output | 1 | Host request ready |
| ha_opcode_i | input | 3 | Host request opcode |
| ha_size_i | input | 3 | Host request size (log2 bytes) |
| ha_source_i | input | SRC_W | Host source ID |
| ha_address_i | input | ADDR_W | Host byte address |
| ha_mask_i | input | WIDE_W/8 | Host byte mask |
| ha_data_i | input | WIDE_W | Host write data |
| hd_valid_o | output | 1 | Wide response valid |
| hd_ready_i | input | 1 | Wide response ready |
| hd_opcode_o | output | 3 | Wide response opcode |
| hd_size_o | output | 3 | Wide response size |
| hd_source_o | output | SRC_W | Wide response source ID |
| hd_data_o | output | WIDE_W | Wide response data |
| hd_error_o | output | 1 | Wide response error |
| hd_rsp_intg_o | output | 8 | Wide response check byte |
| hd_data_intg_o | output | 8 | Wide data check byte |
| da_valid_o | output | 1 | Narrow request valid |
| da_ready_i | input | 1 | Narrow request ready |
| da_opcode_o | output | 3 | Narrow request opcode |
| da_size_o | output | 3 | Narrow request size |
| da_source_o | output | TAG_W | Narrow lane tag |
| da_address_o | output | ADDR_W | Narrow byte address |
| da_mask_o | output | NARROW_W/8 | Narrow byte mask |
| da_data_o | output | NARROW_W | Narrow write data |
| da_cmd_intg_o | output | 8 | Narrow command check byte |
| da_data_intg_o | output | 8 | Narrow data check byte |
| dd_valid_i | input | 1 | Narrow acknowledgement valid |
| dd_ready_o | output | 1 | Narrow acknowledgement ready |
| dd_opcode_i | input | 3 | Narrow acknowledgement opcode |
| dd_size_i | input | 3 | Narrow acknowledgement size |
| dd_source_i | input | TAG_W | Narrow acknowledgement tag |
| dd_data_i | input | NARROW_W | Narrow read data |
| dd_error_i | input | 1 | Narrow acknowledgement error |
| dd_rsp_intg_i | input | 8 | Narrow response check byte |
| dd_data_intg_i | input | 8 | Narrow data check byte |

## Verification
The bench builds the splitter with its defaults: a 128-bit host side, a 32-bit device side, 32-bit addresses and 8-bit sources. That gives four lanes and a 2-bit tag, so every lane subset of interest can be reached with directed masks: full, alternating, a single lane and empty. Four lanes also allow reversed and shuffled acknowledgement orders, a device stall on the first beat, and a held wide response. Error injection, either through the device error bit or through a corrupted data check byte on one lane, exercises the merged error bit and its clearing between transactions.

// File: rtl/wns_pkg.sv
package wns_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} state_e;

  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_GET      = 3'd4;
  localparam logic [2:0] OP_ACK      = 3'd0;
  localparam logic [2:0] OP_ACK_DATA = 3'd1;

  function automatic logic [7:0] data_intg(input logic [127:0] d);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) r ^= d[8*i +: 8];
    return r;
  endfunction

  function automatic logic [7:0] cmd_intg(input logic [2:0] op, input logic [2:0] size,
                                          input logic [31:0] addr, input logic [15:0] mask);
    logic [7:0] r;
    r = {5'b0, op} ^ {5'b0, size} ^ mask[7:0] ^ mask[15:8];
    for (int i = 0; i < 4; i++) r ^= addr[8*i +: 8];
    return r;
  endfunction

  function automatic logic [7:0] rsp_intg(input logic [2:0] op, input logic [2:0] size,
                                          input logic [7:0] src, input logic err);
    return {5'b0, op} ^ {5'b0, size} ^ src ^ {7'b0, err};
  endfunction
endpackage

// File: rtl/wns_issue.sv
module wns_issue import wns_pkg::*; #(
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [WIDE_W/NARROW_W-1:0]   lanes_i,
  input  logic [2:0]                   opcode_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WIDE_W-1:0]            data_i,
  input  logic [WIDE_W/8-1:0]          mask_i,
  output logic                         busy_o,
  output logic                         da_valid_o,
  input  logic                         da_ready_i,
  output logic [2:0]                   da_opcode_o,
  output logic [2:0]                   da_size_o,
  output logic [((WIDE_W/NARROW_W) > 1 ? $clog2(WIDE_W/NARROW_W) : 1)-1:0] da_source_o,
  output logic [ADDR_W-1:0]            da_address_o,
  output logic [NARROW_W/8-1:0]        da_mask_o,
  output logic [NARROW_W-1:0]          da_data_o,
  output logic [7:0]                   da_cmd_intg_o,
  output logic [7:0]                   da_data_intg_o
);
  localparam int LANES  = WIDE_W / NARROW_W;
  localparam int LB     = NARROW_W / 8;
  localparam int MASK_W = WIDE_W / 8;
  localparam int TAG_W  = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0] pend_q;
  logic [TAG_W-1:0] sel;

  // lowest pending lane wins
  always_comb begin
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = TAG_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pend_q      <= '0;
    else if (start_i)                   pend_q      <= lanes_i;
    else if (da_valid_o && da_ready_i)  pend_q[sel] <= 1'b0;
  end

  assign busy_o       = |pend_q;
  assign da_valid_o   = |pend_q;
  assign da_opcode_o  = opcode_i;
  assign da_size_o    = 3'($clog2(LB));
  assign da_source_o  = sel;
  assign da_address_o = (addr_i & ~ADDR_W'(MASK_W - 1)) + ADDR_W'(sel) * ADDR_W'(LB);
  assign da_data_o    = data_i[sel*NARROW_W +: NARROW_W];
  assign da_mask_o    = mask_i[sel*LB +: LB];

  assign da_cmd_intg_o  = cmd_intg(da_opcode_o, da_size_o, 32'(da_address_o), 16'(da_mask_o));
  assign da_data_intg_o = data_intg(128'(da_data_o));

  a_r4_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_o && !da_ready_i) |=> (da_valid_o && $stable(da_address_o) && $stable(da_source_o)));

  a_r3_beat_has_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    da_valid_o |-> (da_mask_o != '0));
endmodule

// File: rtl/wns_collect.sv
module wns_collect import wns_pkg::*; #(
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [WIDE_W/NARROW_W-1:0]   lanes_i,
  input  logic                         is_get_i,
  input  logic                         dd_valid_i,
  output logic                         dd_ready_o,
  input  logic [2:0]                   dd_opcode_i,
  input  logic [2:0]                   dd_size_i,
  input  logic [((WIDE_W/NARROW_W) > 1 ? $clog2(WIDE_W/NARROW_W) : 1)-1:0] dd_source_i,
  input  logic [NARROW_W-1:0]          dd_data_i,
  input  logic                         dd_error_i,
  input  logic [7:0]                   dd_rsp_intg_i,
  input  logic [7:0]                   dd_data_intg_i,
  output logic                         busy_o,
  output logic [WIDE_W-1:0]            rdata_o,
  output logic                         err_o
);
  localparam int LANES = WIDE_W / NARROW_W;
  localparam int TAG_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0] pend_q;
  logic             err_q;
  logic             hit;
  logic             bad_chk;

  assign dd_ready_o = |pend_q;
  assign busy_o     = |pend_q;
  assign hit        = dd_valid_i && dd_ready_o && pend_q[dd_source_i];
  assign bad_chk    = (dd_rsp_intg_i != rsp_intg(dd_opcode_i, dd_size_i, 8'(dd_source_i), dd_error_i))
                   || (dd_data_intg_i != data_intg(128'(dd_data_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      err_q  <= 1'b0;
    end else if (start_i) begin
      pend_q <= lanes_i;
      err_q  <= 1'b0;
    end else if (hit) begin
      pend_q[dd_source_i] <= 1'b0;
      err_q               <= err_q | dd_error_i | bad_chk;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NARROW_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                             lane_q <= '0;
      else if (start_i)                                        lane_q <= '0;
      else if (hit && is_get_i && dd_source_i == TAG_W'(g))    lane_q <= dd_data_i;
    end
    assign rdata_o[g*NARROW_W +: NARROW_W] = lane_q;
  end

  assign err_o = err_q;

  a_r9_dev_error_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && dd_error_i && !start_i) |=> err_o);

  a_r6_ack_known_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dd_valid_i && dd_ready_o) |-> pend_q[dd_source_i]);
endmodule

// File: rtl/wide_narrow_splitter.sv
module wide_narrow_splitter import wns_pkg::*; #(
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 32,
  parameter int SRC_W    = 8,
  localparam int LANES   = WIDE_W / NARROW_W,
  localparam int TAG_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int MASK_W  = WIDE_W / 8,
  localparam int LB      = NARROW_W / 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ha_valid_i,
  output logic                 ha_ready_o,
  input  logic [2:0]           ha_opcode_i,
  input  logic [2:0]           ha_size_i,
  input  logic [SRC_W-1:0]     ha_source_i,
  input  logic [ADDR_W-1:0]    ha_address_i,
  input  logic [MASK_W-1:0]    ha_mask_i,
  input  logic [WIDE_W-1:0]    ha_data_i,
  output logic                 hd_valid_o,
  input  logic                 hd_ready_i,
  output logic [2:0]           hd_opcode_o,
  output logic [2:0]           hd_size_o,
  output logic [SRC_W-1:0]     hd_source_o,
  output logic [WIDE_W-1:0]    hd_data_o,
  output logic                 hd_error_o,
  output logic [7:0]           hd_rsp_intg_o,
  output logic [7:0]           hd_data_intg_o,
  output logic                 da_valid_o,
  input  logic                 da_ready_i,
  output logic [2:0]           da_opcode_o,
  output logic [2:0]           da_size_o,
  output logic [TAG_W-1:0]     da_source_o,
  output logic [ADDR_W-1:0]    da_address_o,
  output logic [LB-1:0]        da_mask_o,
  output logic [NARROW_W-1:0]  da_data_o,
  output logic [7:0]           da_cmd_intg_o,
  output logic [7:0]           da_data_intg_o,
  input  logic                 dd_valid_i,
  output logic                 dd_ready_o,
  input  logic [2:0]           dd_opcode_i,
  input  logic [2:0]           dd_size_i,
  input  logic [TAG_W-1:0]     dd_source_i,
  input  logic [NARROW_W-1:0]  dd_data_i,
  input  logic                 dd_error_i,
  input  logic [7:0]           dd_rsp_intg_i,
  input  logic [7:0]           dd_data_intg_i
);
  state_e              state_q, state_d;
  logic [2:0]          op_q, size_q;
  logic [SRC_W-1:0]    src_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WIDE_W-1:0]   data_q;
  logic [MASK_W-1:0]   mask_q;
  logic [LANES-1:0]    lanes_c;
  logic                accept, is_get_q, issue_busy, ack_busy, err_w;
  logic [WIDE_W-1:0]   rdata_w;

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    assign lanes_c[g] = |ha_mask_i[g*LB +: LB];
  end

  assign ha_ready_o = (state_q == ST_IDLE);
  assign accept     = ha_valid_i && ha_ready_o;
  assign is_get_q   = (op_q == OP_GET);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)                    state_d = ST_BUSY;
      ST_BUSY: if (!issue_busy && !ack_busy)  state_d = ST_RESP;
      ST_RESP: if (hd_ready_i)                state_d = ST_IDLE;
      default:                                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      size_q  <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= ha_opcode_i;
        size_q <= ha_size_i;
        src_q  <= ha_source_i;
        addr_q <= ha_address_i;
        data_q <= ha_data_i;
        mask_q <= ha_mask_i;
      end
    end
  end

  wns_issue #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)) u_issue (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (accept),
    .lanes_i       (lanes_c),
    .opcode_i      (op_q),
    .addr_i        (addr_q),
    .data_i        (data_q),
    .mask_i        (mask_q),
    .busy_o        (issue_busy),
    .da_valid_o    (da_valid_o),
    .da_ready_i    (da_ready_i),
    .da_opcode_o   (da_opcode_o),
    .da_size_o     (da_size_o),
    .da_source_o   (da_source_o),
    .da_address_o  (da_address_o),
    .da_mask_o     (da_mask_o),
    .da_data_o     (da_data_o),
    .da_cmd_intg_o (da_cmd_intg_o),
    .da_data_intg_o(da_data_intg_o)
  );

  wns_collect #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_collect (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (accept),
    .lanes_i       (lanes_c),
    .is_get_i      (is_get_q),
    .dd_valid_i    (dd_valid_i),
    .dd_ready_o    (dd_ready_o),
    .dd_opcode_i   (dd_opcode_i),
    .dd_size_i     (dd_size_i),
    .dd_source_i   (dd_source_i),
    .dd_data_i     (dd_data_i),
    .dd_error_i    (dd_error_i),
    .dd_rsp_intg_i (dd_rsp_intg_i),
    .dd_data_intg_i(dd_data_intg_i),
    .busy_o        (ack_busy),
    .rdata_o       (rdata_w),
    .err_o         (err_w)
  );

  assign hd_valid_o     = (state_q == ST_RESP);
  assign hd_opcode_o    = is_get_q ? OP_ACK_DATA : OP_ACK;
  assign hd_size_o      = size_q;
  assign hd_source_o    = src_q;
  assign hd_data_o      = rdata_w;
  assign hd_error_o     = err_w;
  assign hd_rsp_intg_o  = rsp_intg(hd_opcode_o, hd_size_o, 8'(hd_source_o), hd_error_o);
  assign hd_data_intg_o = data_intg(128'(hd_data_o));

  a_r1_ready_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ha_ready_o);

  a_r11_resp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hd_valid_o && !hd_ready_i) |=>
      (hd_valid_o && $stable(hd_source_o) && $stable(hd_data_o) && $stable(hd_error_o)));

  a_r6_resp_after_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd_valid_o |-> (!ack_busy && !issue_busy && !da_valid_o));

  a_r3_empty_mask_no_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && ha_mask_i == '0) |=> !da_valid_o);
endmodule

// File: tb/wide_narrow_splitter_tb.sv
`timescale 1ns/1ps
module wide_narrow_splitter_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         ha_valid_i, ha_ready_o;
  logic [2:0]   ha_opcode_i, ha_size_i;
  logic [7:0]   ha_source_i;
  logic [31:0]  ha_address_i;
  logic [15:0]  ha_mask_i;
  logic [127:0] ha_data_i;
  logic         hd_valid_o, hd_ready_i;
  logic [2:0]   hd_opcode_o, hd_size_o;
  logic [7:0]   hd_source_o;
  logic [127:0] hd_data_o;
  logic         hd_error_o;
  logic [7:0]   hd_rsp_intg_o, hd_data_intg_o;
  logic         da_valid_o, da_ready_i;
  logic [2:0]   da_opcode_o, da_size_o;
  logic [1:0]   da_source_o;
  logic [31:0]  da_address_o;
  logic [3:0]   da_mask_o;
  logic [31:0]  da_data_o;
  logic [7:0]   da_cmd_intg_o, da_data_intg_o;
  logic         dd_valid_i, dd_ready_o;
  logic [2:0]   dd_opcode_i, dd_size_i;
  logic [1:0]   dd_source_i;
  logic [31:0]  dd_data_i;
  logic         dd_error_i;
  logic [7:0]   dd_rsp_intg_i, dd_data_intg_i;

  always #2 clk_i = ~clk_i;

  wide_narrow_splitter dut_i (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input string req, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_data(input logic [127:0] d);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 16; i++) r = r ^ d[8*i +: 8];
    return r;
  endfunction
  function automatic logic [7:0] m_cmd(input logic [2:0] op, input logic [2:0] sz,
                                       input logic [31:0] a, input logic [15:0] m);
    return {5'b0, op} ^ {5'b0, sz} ^ m[7:0] ^ m[15:8] ^ a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24];
  endfunction
  function automatic logic [7:0] m_rsp(input logic [2:0] op, input logic [2:0] sz,
                                       input logic [7:0] s, input logic e);
    return {5'b0, op} ^ {5'b0, sz} ^ s ^ {7'b0, e};
  endfunction

  task automatic run_txn(input logic [2:0] op, input logic [31:0] addr, input logic [15:0] mask,
                         input logic [127:0] data, input logic [7:0] src, input int ord[4],
                         input logic [31:0] rd[4], input int err_lane, input int bad_lane,
                         input int stall, input int hold);
    bit req_l[4];
    int exp_l[4];
    int n_exp = 0;
    int nb = 0, cyc = 0, stl, w = 0, l;
    bit snap_ok = 1'b0;
    logic [31:0] snap_a;
    logic [1:0]  snap_s;
    logic [127:0] expd = '0;
    logic exp_err = 1'b0;
    logic [2:0] exp_op;
    logic is_get = (op == 3'd4);
    logic [31:0] base = addr & ~32'hF;
    logic [31:0] ddat;
    for (int i = 0; i < 4; i++) begin
      req_l[i] = (mask[4*i +: 4] != 4'h0);
      if (req_l[i]) begin
        exp_l[n_exp] = i;
        n_exp++;
        if (is_get) expd[32*i +: 32] = rd[i];
        if (i == err_lane || i == bad_lane) exp_err = 1'b1;
      end
    end
    exp_op = is_get ? 3'd1 : 3'd0;

    @(negedge clk_i);
    chk("R1", "ready when idle", ha_ready_o, 1);
    ha_opcode_i = op; ha_size_i = 3'd4; ha_source_i = src; ha_address_i = addr;
    ha_mask_i = mask; ha_data_i = data; ha_valid_i = 1'b1;
    @(negedge clk_i);
    ha_valid_i = 1'b0;
    stl = stall;
    da_ready_i = (stall == 0);
    while (nb < n_exp && cyc < 60) begin
      chk("R1", "ready low in flight", ha_ready_o, 0);
      if (da_valid_o) begin
        if (stl > 0) begin
          if (!snap_ok) begin snap_a = da_address_o; snap_s = da_source_o; snap_ok = 1'b1; end
          else begin
            chk("R4", "stalled address", da_address_o, snap_a);
            chk("R4", "stalled tag", da_source_o, snap_s);
          end
          stl--;
        end
        if (stl == 0) begin
          da_ready_i = 1'b1;
          l = exp_l[nb];
          chk("R2", "beat tag", da_source_o, l);
          chk("R2", "beat address", da_address_o, base + 32'(4 * l));
          chk("R2", "beat data", da_data_o, data[32*l +: 32]);
          chk("R2", "beat mask", da_mask_o, mask[4*l +: 4]);
          chk("R2", "beat size", da_size_o, 2);
          chk("R2", "beat opcode", da_opcode_o, op);
          chk("R5", "beat cmd check", da_cmd_intg_o,
              m_cmd(op, 3'd2, base + 32'(4 * l), {12'h0, mask[4*l +: 4]}));
          chk("R5", "beat data check", da_data_intg_o, m_data({96'h0, data[32*l +: 32]}));
          nb++;
        end
      end
      @(negedge clk_i);
      cyc++;
    end
    chk("R3", "beat count", nb, n_exp);
    chk("R3", "no extra beat", da_valid_o, 0);

    for (int k = 0; k < 4; k++) begin
      l = ord[k];
      if (!req_l[l]) continue;
      chk("R6", "ack ready", dd_ready_o, 1);
      chk("R6", "no early response", hd_valid_o, 0);
      ddat = is_get ? rd[l] : 32'h0;
      dd_opcode_i = exp_op; dd_size_i = 3'd2; dd_source_i = 2'(l); dd_data_i = ddat;
      dd_error_i = (l == err_lane);
      dd_rsp_intg_i = m_rsp(exp_op, 3'd2, {6'h0, 2'(l)}, (l == err_lane));
      dd_data_intg_i = m_data({96'h0, ddat}) ^ ((l == bad_lane) ? 8'h01 : 8'h00);
      dd_valid_i = 1'b1;
      @(negedge clk_i);
    end
    dd_valid_i = 1'b0;

    hd_ready_i = 1'b0;
    while (!hd_valid_o && w < 10) begin @(negedge clk_i); w++; end
    chk("R6", "response valid", hd_valid_o, 1);
    chk("R7", "response opcode", hd_opcode_o, exp_op);
    chk("R7", "response source", hd_source_o, src);
    chk("R7", "response size", hd_size_o, 4);
    chk("R8", "response data", hd_data_o, expd);
    chk("R9", "response error", hd_error_o, exp_err);
    chk("R10", "response check", hd_rsp_intg_o, m_rsp(exp_op, 3'd4, src, exp_err));
    chk("R10", "response data check", hd_data_intg_o, m_data(expd));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk_i);
      chk("R11", "held valid", hd_valid_o, 1);
      chk("R11", "held source", hd_source_o, src);
      chk("R11", "held data", hd_data_o, expd);
      chk("R11", "held error", hd_error_o, exp_err);
      chk("R1", "ready low while response waits", ha_ready_o, 0);
    end
    hd_ready_i = 1'b1;
    @(negedge clk_i);
    hd_ready_i = 1'b0;
    chk("R6", "single response", hd_valid_o, 0);
    chk("R1", "ready after response", ha_ready_o, 1);
  endtask

  task automatic t_full_write();
    run_txn(3'd0, 32'h2000_0000, 16'hFFFF, 128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF00,
            8'h05, '{3, 2, 1, 0}, '{0, 0, 0, 0}, -1, -1, 0, 0);
  endtask
  task automatic t_sparse_write();
    run_txn(3'd0, 32'h4001_0000, 16'hF0F0, 128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF00,
            8'h3C, '{3, 2, 1, 0}, '{0, 0, 0, 0}, -1, -1, 0, 0);
  endtask
  task automatic t_single_read();
    run_txn(3'd4, 32'h0000_0008, 16'h0F00, 128'h0, 8'h01, '{0, 1, 2, 3},
            '{32'hAAAA_0000, 32'hBBBB_0000, 32'h0000_0001, 32'hCCCC_0000}, -1, -1, 0, 0);
  endtask
  task automatic t_full_read_stall();
    run_txn(3'd4, 32'h1000_0030, 16'hFFFF, 128'h0, 8'hA7, '{2, 0, 3, 1},
            '{32'h0102_0304, 32'hA5A5_5A5A, 32'hDEAD_BEEF, 32'h8000_0001}, -1, -1, 3, 0);
  endtask
  task automatic t_device_error();
    run_txn(3'd0, 32'h4002_0000, 16'h00FF, 128'h0000_0000_0000_0000_CAFE_F00D_1234_5678,
            8'h11, '{1, 0, 2, 3}, '{0, 0, 0, 0}, 1, -1, 0, 0);
    // error must not carry into next transaction
    run_txn(3'd0, 32'h4002_0000, 16'h000F, 128'h55, 8'h12, '{0, 1, 2, 3},
            '{0, 0, 0, 0}, -1, -1, 0, 0);
  endtask
  task automatic t_bad_intg();
    run_txn(3'd4, 32'h3000_0000, 16'hFF00, 128'h0, 8'h22, '{3, 2, 1, 0},
            '{32'h1, 32'h2, 32'h3333_0000, 32'h4444_0000}, -1, 2, 0, 0);
  endtask
  task automatic t_empty_mask();
    run_txn(3'd0, 32'h2000_0040, 16'h0000, 128'hFFFF, 8'h44, '{0, 1, 2, 3},
            '{0, 0, 0, 0}, -1, -1, 0, 0);
  endtask
  task automatic t_resp_hold();
    run_txn(3'd4, 32'h0003_0000, 16'h000F, 128'h0, 8'h9E, '{0, 1, 2, 3},
            '{32'hDEAD_BEEF, 0, 0, 0}, -1, -1, 0, 3);
  endtask

  initial begin
    rst_ni = 1'b0;
    ha_valid_i = 0; ha_opcode_i = 0; ha_size_i = 0; ha_source_i = 0; ha_address_i = 0;
    ha_mask_i = 0; ha_data_i = 0; hd_ready_i = 0; da_ready_i = 0;
    dd_valid_i = 0; dd_opcode_i = 0; dd_size_i = 0; dd_source_i = 0; dd_data_i = 0;
    dd_error_i = 0; dd_rsp_intg_i = 0; dd_data_intg_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R12", "reset ha_ready", ha_ready_o, 1);
    chk("R12", "reset da_valid", da_valid_o, 0);
    chk("R12", "reset dd_ready", dd_ready_o, 0);
    chk("R12", "reset hd_valid", hd_valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_full_write();
    t_sparse_write();
    t_single_read();
    t_full_read_stall();
    t_device_error();
    t_bad_intg();
    t_empty_mask();
    t_resp_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule